// File: doc/BRIEF.md
# Dual Warp Issue Dispatcher

This block sits inside one multiprocessor of a many-core GPU and decides, every clock, which warps (groups of 32 threads) leave for the execution hardware. Thread blocks have already been placed on the multiprocessor by a higher level. Here, two schedulers each pick at most one warp per cycle. One scheduler owns the even warp IDs and the other owns the odd ones. A picked warp goes to one of four execution columns: two 16-lane core columns for integer and single-precision work, a load/store column, and a special-function column.

Each warp presents a ready flag and a 3-bit instruction class. A warp is eligible when it is ready, was not granted in the previous cycle, and the column or columns its class needs are free. Each scheduler scans its eligible warps round-robin, starting just after the warp it last granted. The even scheduler claims its columns first. The odd scheduler may then claim only what is left.

Each column has a small state machine with two states. `COL_IDLE` means the column is free. `COL_HELD` means it is occupied. The CLAIM transition (`COL_IDLE` to `COL_HELD`) happens on a grant when the class needs more than one cycle. The DRAIN transition (`COL_HELD` to `COL_HELD`) counts down the remaining cycles. The RELEASE transition (`COL_HELD` to `COL_IDLE`) happens when the count reaches its last cycle. A double-precision warp claims both core columns together.

Top module: `warp_dual_dispatch`

## Requirements
- R1: While reset is held and right after it, `col_busy` is 0 and there are no grants when nothing is ready. After reset, warp 0 has first priority in the even scheduler and warp 1 in the odd scheduler.
- R2: Warp w's class is `warp_class[3w+2:3w]`. Column bits are the same in grant masks and `col_busy`: bit0 is core A, bit1 is core B, bit2 is load/store and bit3 is special-function. Class 0 (integer) and class 1 (FP32) take the lowest-numbered free core column, so `0001` before `0010`. Class 2 (FP64) takes `0011`. Class 3 (load/store) takes `0100`. Class 4 (special-function) takes `1000`. Classes 5 to 7 are never granted.
- R3: A grant occupies its column for the grant cycle plus the cycles that follow. `col_busy` is high for those following cycles. The total occupancy is 2 cycles for a core or load/store grant, 2 cycles for an FP64 grant, and 8 cycles for a special-function grant.
- R4: No column is granted while its `col_busy` bit is high, and the two grants of one cycle never share a column.
- R5: An FP64 warp is granted only when both core columns are free and neither is claimed by the even scheduler in that cycle. While an FP64 warp holds the core columns, no core grant is made.
- R6: `ev_gnt_warp` is always even and `od_gnt_warp` is always odd.
- R7: Each scheduler grants the first eligible warp of its own parity, scanning upward from the warp after the one it last granted and wrapping around.
- R8: If the odd scheduler's chosen warp needs a column taken by the even scheduler in the same cycle, the odd scheduler grants nothing that cycle. Its round-robin position is unchanged, so it picks the same warp again on its next try.
- R9: A granted warp is not granted in the cycle after its grant, even if it is still ready and a suitable column is free.
- R10: A warp whose ready flag is low is never granted.
- R11: Eight special-function warps, all ready at once on an idle block, are granted every 8 cycles. The special-function column becomes free 64 cycles after the first grant.
- R12: Both schedulers can grant in the same cycle when their columns differ. This includes two integer warps going to core A and core B.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| warp_ready | input | NUM_WARPS | Per-warp ready flag |
| warp_class | input | 3*NUM_WARPS | Per-warp instruction class, 3 bits per warp |
| ev_gnt_vld | output | 1 | The even scheduler grants a warp this cycle |
| ev_gnt_warp | output | log2(NUM_WARPS) | Warp ID granted by the even scheduler |
| ev_gnt_cols | output | 4 | Columns claimed by the even grant |
| od_gnt_vld | output | 1 | The odd scheduler grants a warp this cycle |
| od_gnt_warp | output | log2(NUM_WARPS) | Warp ID granted by the odd scheduler |
| od_gnt_cols | output | 4 | Columns claimed by the odd grant |
| col_busy | output | 4 | Column occupied by an earlier grant |

## Verification
Two situations are the hardest to reach from the ports. One is the odd scheduler losing a column to the even scheduler in the same cycle. The other is an FP64 warp locking out a core warp of the other parity. Both need every column idle and a particular pair of classes becoming ready in the same cycle. The stimulus therefore parks the block with nothing ready until every column has drained. It then raises exactly the two competing warps together and checks the lost cycle, the busy cycle and the retry one by one. A long mixed run then drives random readiness and random classes, including the invalid codes. On every clock it compares all outputs with a behavioural model of the scheduling rules.

// File: rtl/wdd_pkg.sv
package wdd_pkg;

    localparam int NUM_COLS  = 4;
    localparam int COL_CORE_A = 0;
    localparam int COL_CORE_B = 1;
    localparam int COL_MEM    = 2;
    localparam int COL_SFU    = 3;

    localparam logic [2:0] CLS_INT  = 3'd0;
    localparam logic [2:0] CLS_FP32 = 3'd1;
    localparam logic [2:0] CLS_FP64 = 3'd2;
    localparam logic [2:0] CLS_MEM  = 3'd3;
    localparam logic [2:0] CLS_SFU  = 3'd4;

    typedef enum logic [1:0] {
        COL_IDLE = 2'd0,
        COL_HELD = 2'd1
    } col_state_e;

    // Column set a class would take given the currently available columns;
    // zero when the class cannot issue.
    function automatic logic [NUM_COLS-1:0] wdd_fit_cols(
        input logic [2:0]          cls,
        input logic [NUM_COLS-1:0] avail
    );
        logic [NUM_COLS-1:0] cols;
        cols = '0;
        unique case (cls)
            CLS_INT, CLS_FP32: begin
                if (avail[COL_CORE_A])      cols[COL_CORE_A] = 1'b1;
                else if (avail[COL_CORE_B]) cols[COL_CORE_B] = 1'b1;
            end
            CLS_FP64: begin
                if (avail[COL_CORE_A] && avail[COL_CORE_B]) begin
                    cols[COL_CORE_A] = 1'b1;
                    cols[COL_CORE_B] = 1'b1;
                end
            end
            CLS_MEM: cols[COL_MEM] = avail[COL_MEM];
            CLS_SFU: cols[COL_SFU] = avail[COL_SFU];
            default: cols = '0;
        endcase
        return cols;
    endfunction

endpackage

// File: rtl/wdd_col_track.sv
module wdd_col_track
    import wdd_pkg::*;
#(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             claim,
    input  logic [CNT_W-1:0] load_val,
    output logic             busy
);

    col_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= COL_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            COL_IDLE: begin
                // CLAIM: a grant that occupies more than its own cycle
                if (claim && (load_val != '0)) begin
                    state_d = COL_HELD;
                    cnt_d   = load_val;
                end
            end
            COL_HELD: begin
                if (cnt_q <= CNT_W'(1)) begin
                    // RELEASE
                    state_d = COL_IDLE;
                    cnt_d   = '0;
                end else begin
                    // DRAIN
                    cnt_d = cnt_q - CNT_W'(1);
                end
            end
            default: begin
                state_d = COL_IDLE;
                cnt_d   = '0;
            end
        endcase
    end

    assign busy = (state_q == COL_HELD);

endmodule

// File: rtl/wdd_warp_sched.sv
module wdd_warp_sched #(
    parameter  int N  = 8,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  elig,
    input  logic          take,
    output logic          cand_vld,
    output logic [IW-1:0] cand_idx
);

    logic [IW-1:0] ptr_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q <= IW'(N - 1);
        end else if (take) begin
            ptr_q <= cand_idx;
        end
    end

    // Scan starts one past the last granted entry and wraps.
    always_comb begin
        cand_vld = 1'b0;
        cand_idx = '0;
        for (int k = 1; k <= N; k++) begin
            int p;
            p = (int'(ptr_q) + k) % N;
            if (!cand_vld && elig[p]) begin
                cand_vld = 1'b1;
                cand_idx = IW'(p);
            end
        end
    end

endmodule

// File: rtl/wdd_pair_arb.sv
module wdd_pair_arb
    import wdd_pkg::*;
(
    input  logic                ev_vld,
    input  logic [2:0]          ev_cls,
    input  logic                od_vld,
    input  logic [2:0]          od_cls,
    input  logic [NUM_COLS-1:0] avail,
    output logic                ev_take,
    output logic [NUM_COLS-1:0] ev_cols,
    output logic                od_take,
    output logic [NUM_COLS-1:0] od_cols
);

    // Even side claims first; odd side sees only what remains.
    always_comb begin
        ev_cols = ev_vld ? wdd_fit_cols(ev_cls, avail) : '0;
        od_cols = od_vld ? wdd_fit_cols(od_cls, avail & ~ev_cols) : '0;
        ev_take = |ev_cols;
        od_take = |od_cols;
    end

endmodule

// File: rtl/warp_dual_dispatch.sv
module warp_dual_dispatch
    import wdd_pkg::*;
#(
    parameter int NUM_WARPS = 16,
    parameter int CORE_OCC  = 2,
    parameter int MEM_OCC   = 2,
    parameter int SFU_OCC   = 8,
    parameter int DP_OCC    = 2
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [NUM_WARPS-1:0]         warp_ready,
    input  logic [3*NUM_WARPS-1:0]       warp_class,
    output logic                         ev_gnt_vld,
    output logic [$clog2(NUM_WARPS)-1:0] ev_gnt_warp,
    output logic [3:0]                   ev_gnt_cols,
    output logic                         od_gnt_vld,
    output logic [$clog2(NUM_WARPS)-1:0] od_gnt_warp,
    output logic [3:0]                   od_gnt_cols,
    output logic [3:0]                   col_busy
);

    localparam int HALF    = NUM_WARPS / 2;
    localparam int LID_W   = $clog2(HALF);
    localparam int WID_W   = LID_W + 1;
    localparam int MAX_A   = (CORE_OCC > MEM_OCC) ? CORE_OCC : MEM_OCC;
    localparam int MAX_B   = (SFU_OCC > DP_OCC) ? SFU_OCC : DP_OCC;
    localparam int MAX_OCC = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int CNT_W   = $clog2(MAX_OCC + 1);

    logic [NUM_COLS-1:0]  busy_w;
    logic [NUM_COLS-1:0]  avail;
    logic [2:0]           cls_a [NUM_WARPS];
    logic [NUM_WARPS-1:0] elig;
    logic [NUM_WARPS-1:0] mask_q, mask_d;
    logic [HALF-1:0]      ev_elig, od_elig;

    logic                 ev_cand_vld, od_cand_vld;
    logic [LID_W-1:0]     ev_cand_idx, od_cand_idx;
    logic [WID_W-1:0]     ev_warp, od_warp;
    logic [2:0]           ev_cls, od_cls;
    logic                 ev_take, od_take;
    logic [NUM_COLS-1:0]  ev_cols, od_cols;
    logic [NUM_COLS-1:0]  claim;
    logic                 pair_claim;

    assign avail = ~busy_w;

    for (genvar w = 0; w < NUM_WARPS; w++) begin : g_warp
        assign cls_a[w] = warp_class[3*w +: 3];
        assign elig[w]  = warp_ready[w] & ~mask_q[w]
                        & (|wdd_fit_cols(cls_a[w], avail));
    end

    for (genvar i = 0; i < HALF; i++) begin : g_split
        assign ev_elig[i] = elig[2*i];
        assign od_elig[i] = elig[2*i+1];
    end

    wdd_warp_sched #(.N(HALF)) u_ev_sched (
        .clk      (clk),
        .rst_n    (rst_n),
        .elig     (ev_elig),
        .take     (ev_take),
        .cand_vld (ev_cand_vld),
        .cand_idx (ev_cand_idx)
    );

    wdd_warp_sched #(.N(HALF)) u_od_sched (
        .clk      (clk),
        .rst_n    (rst_n),
        .elig     (od_elig),
        .take     (od_take),
        .cand_vld (od_cand_vld),
        .cand_idx (od_cand_idx)
    );

    assign ev_warp = {ev_cand_idx, 1'b0};
    assign od_warp = {od_cand_idx, 1'b1};
    assign ev_cls  = cls_a[ev_warp];
    assign od_cls  = cls_a[od_warp];

    wdd_pair_arb u_arb (
        .ev_vld  (ev_cand_vld),
        .ev_cls  (ev_cls),
        .od_vld  (od_cand_vld),
        .od_cls  (od_cls),
        .avail   (avail),
        .ev_take (ev_take),
        .ev_cols (ev_cols),
        .od_take (od_take),
        .od_cols (od_cols)
    );

    assign claim      = ev_cols | od_cols;
    assign pair_claim = (ev_cols == 4'b0011) | (od_cols == 4'b0011);

    for (genvar c = 0; c < NUM_COLS; c++) begin : g_col
        logic [CNT_W-1:0] load_v;
        if (c == COL_CORE_A || c == COL_CORE_B) begin : g_core
            assign load_v = pair_claim ? CNT_W'(DP_OCC - 1) : CNT_W'(CORE_OCC - 1);
        end else if (c == COL_MEM) begin : g_mem
            assign load_v = CNT_W'(MEM_OCC - 1);
        end else begin : g_sfu
            assign load_v = CNT_W'(SFU_OCC - 1);
        end
        wdd_col_track #(.CNT_W(CNT_W)) u_col (
            .clk      (clk),
            .rst_n    (rst_n),
            .claim    (claim[c]),
            .load_val (load_v),
            .busy     (busy_w[c])
        );
    end

    always_comb begin
        mask_d = '0;
        if (ev_take) mask_d[ev_warp] = 1'b1;
        if (od_take) mask_d[od_warp] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) mask_q <= '0;
        else        mask_q <= mask_d;
    end

    assign ev_gnt_vld  = ev_take;
    assign ev_gnt_warp = ev_warp;
    assign ev_gnt_cols = ev_cols;
    assign od_gnt_vld  = od_take;
    assign od_gnt_warp = od_warp;
    assign od_gnt_cols = od_cols;
    assign col_busy    = busy_w;

endmodule

// File: rtl/wdd_dispatch_chk.sv
module wdd_dispatch_chk #(
    parameter int NUM_WARPS = 16,
    parameter int SFU_OCC   = 8,
    parameter int DP_OCC    = 2
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic [NUM_WARPS-1:0]         warp_ready,
    input logic                         ev_gnt_vld,
    input logic [$clog2(NUM_WARPS)-1:0] ev_gnt_warp,
    input logic [3:0]                   ev_gnt_cols,
    input logic                         od_gnt_vld,
    input logic [$clog2(NUM_WARPS)-1:0] od_gnt_warp,
    input logic [3:0]                   od_gnt_cols,
    input logic [3:0]                   col_busy
);

    AST_NO_DOUBLE_BOOK: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_gnt_vld && od_gnt_vld) |-> ((ev_gnt_cols & od_gnt_cols) == 4'b0000)); // R4

    AST_BUSY_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        ((ev_gnt_cols | od_gnt_cols) & col_busy) == 4'b0000); // R4

    AST_SFU_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        ((SFU_OCC > 1) && ((ev_gnt_vld && ev_gnt_cols[3]) || (od_gnt_vld && od_gnt_cols[3])))
        |=> col_busy[3]); // R3

    AST_FP64_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
        ((DP_OCC > 1) && ((ev_gnt_vld && ev_gnt_cols == 4'b0011) ||
                          (od_gnt_vld && od_gnt_cols == 4'b0011)))
        |=> (col_busy[1:0] == 2'b11)); // R5

    AST_EVEN_PARITY: assert property (@(posedge clk) disable iff (!rst_n)
        ev_gnt_vld |-> !ev_gnt_warp[0]); // R6

    AST_ODD_PARITY: assert property (@(posedge clk) disable iff (!rst_n)
        od_gnt_vld |-> od_gnt_warp[0]); // R6

    AST_EVEN_NO_REPEAT: assert property (@(posedge clk) disable iff (!rst_n)
        ev_gnt_vld |=> !(ev_gnt_vld && ev_gnt_warp == $past(ev_gnt_warp))); // R9

    AST_ODD_NO_REPEAT: assert property (@(posedge clk) disable iff (!rst_n)
        od_gnt_vld |=> !(od_gnt_vld && od_gnt_warp == $past(od_gnt_warp))); // R9

    AST_EVEN_READY: assert property (@(posedge clk) disable iff (!rst_n)
        ev_gnt_vld |-> warp_ready[ev_gnt_warp]); // R10

    AST_ODD_READY: assert property (@(posedge clk) disable iff (!rst_n)
        od_gnt_vld |-> warp_ready[od_gnt_warp]); // R10

endmodule

bind warp_dual_dispatch wdd_dispatch_chk #(
    .NUM_WARPS (NUM_WARPS),
    .SFU_OCC   (SFU_OCC),
    .DP_OCC    (DP_OCC)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .warp_ready  (warp_ready),
    .ev_gnt_vld  (ev_gnt_vld),
    .ev_gnt_warp (ev_gnt_warp),
    .ev_gnt_cols (ev_gnt_cols),
    .od_gnt_vld  (od_gnt_vld),
    .od_gnt_warp (od_gnt_warp),
    .od_gnt_cols (od_gnt_cols),
    .col_busy    (col_busy)
);

// File: tb/warp_dual_dispatch_tb_top.sv
module warp_dual_dispatch_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int NW         = 16;
    localparam int H          = NW / 2;
    localparam int WATCHDOG   = 150000;
    localparam int OCC_CORE   = 2;
    localparam int OCC_MEM    = 2;
    localparam int OCC_SFU    = 8;
    localparam int OCC_DP     = 2;

    logic            clk = 1'b0;
    logic            rst_n;
    logic [NW-1:0]   rdy;
    logic [3*NW-1:0] clsv;
    logic            ev_gnt_vld, od_gnt_vld;
    logic [3:0]      ev_gnt_warp, od_gnt_warp;
    logic [3:0]      ev_gnt_cols, od_gnt_cols;
    logic [3:0]      col_busy;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    // behavioural model state
    int rem [4];
    int ptr [2];
    bit msk [NW];

    // outputs observed at the last sample point
    bit       obs_ev_vld, obs_od_vld;
    int       obs_ev_warp, obs_od_warp;
    logic [3:0] obs_ev_cols, obs_od_cols, obs_busy;

    always #(CLK_PERIOD/2) clk = ~clk;

    warp_dual_dispatch dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .warp_ready  (rdy),
        .warp_class  (clsv),
        .ev_gnt_vld  (ev_gnt_vld),
        .ev_gnt_warp (ev_gnt_warp),
        .ev_gnt_cols (ev_gnt_cols),
        .od_gnt_vld  (od_gnt_vld),
        .od_gnt_warp (od_gnt_warp),
        .od_gnt_cols (od_gnt_cols),
        .col_busy    (col_busy)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int cls_of(input int w);
        return int'(clsv[3*w +: 3]);
    endfunction

    task automatic set_cls(input int w, input int c);
        clsv[3*w +: 3] = 3'(c);
    endtask

    // R2 column mapping
    function automatic logic [3:0] fit(input int c, input logic [3:0] av);
        if (c == 0 || c == 1) begin
            if (av[0]) return 4'b0001;
            if (av[1]) return 4'b0010;
            return 4'b0000;
        end
        if (c == 2) return (av[1:0] == 2'b11) ? 4'b0011 : 4'b0000;
        if (c == 3) return av[2] ? 4'b0100 : 4'b0000;
        if (c == 4) return av[3] ? 4'b1000 : 4'b0000;
        return 4'b0000;
    endfunction

    function automatic int occ(input int col, input int c);
        if (col == 3) return OCC_SFU;
        if (col == 2) return OCC_MEM;
        return (c == 2) ? OCC_DP : OCC_CORE;
    endfunction

    task automatic model_reset();
        for (int c = 0; c < 4; c++) rem[c] = 0;
        ptr[0] = H - 1;
        ptr[1] = H - 1;
        for (int w = 0; w < NW; w++) msk[w] = 0;
    endtask

    // One clock: sample and compare away from the edge, then advance the model.
    task automatic step();
        logic [3:0] av, e_c, o_c, exp_busy;
        bit e_v, o_v;
        int e_w, o_w;
        @(negedge clk);
        for (int c = 0; c < 4; c++) av[c] = (rem[c] == 0);
        exp_busy = ~av;
        e_v = 0; o_v = 0; e_w = 0; o_w = 1;
        for (int k = 1; k <= H; k++) begin
            int l, w;
            l = (ptr[0] + k) % H;
            w = 2 * l;
            if (!e_v && rdy[w] && !msk[w] && fit(cls_of(w), av) != 4'b0) begin
                e_v = 1; e_w = w;
            end
        end
        for (int k = 1; k <= H; k++) begin
            int l, w;
            l = (ptr[1] + k) % H;
            w = 2 * l + 1;
            if (!o_v && rdy[w] && !msk[w] && fit(cls_of(w), av) != 4'b0) begin
                o_v = 1; o_w = w;
            end
        end
        e_c = e_v ? fit(cls_of(e_w), av) : 4'b0;
        o_c = o_v ? fit(cls_of(o_w), av & ~e_c) : 4'b0;
        o_v = (o_c != 4'b0);

        obs_ev_vld  = ev_gnt_vld;
        obs_od_vld  = od_gnt_vld;
        obs_ev_warp = int'(ev_gnt_warp);
        obs_od_warp = int'(od_gnt_warp);
        obs_ev_cols = ev_gnt_cols;
        obs_od_cols = od_gnt_cols;
        obs_busy    = col_busy;

        chk(obs_ev_vld == e_v, "R7", "model even grant valid", int'(obs_ev_vld), int'(e_v));
        if (e_v) begin
            chk(obs_ev_warp == e_w, "R7", "model even warp", obs_ev_warp, e_w);
            chk(obs_ev_cols == e_c, "R2", "model even columns", int'(obs_ev_cols), int'(e_c));
        end
        chk(obs_od_vld == o_v, "R8", "model odd grant valid", int'(obs_od_vld), int'(o_v));
        if (o_v) begin
            chk(obs_od_warp == o_w, "R7", "model odd warp", obs_od_warp, o_w);
            chk(obs_od_cols == o_c, "R2", "model odd columns", int'(obs_od_cols), int'(o_c));
        end
        chk(obs_busy == exp_busy, "R3", "model column busy", int'(obs_busy), int'(exp_busy));

        @(posedge clk);
        for (int c = 0; c < 4; c++) begin
            if (e_c[c])      rem[c] = occ(c, cls_of(e_w)) - 1;
            else if (o_c[c]) rem[c] = occ(c, cls_of(o_w)) - 1;
            else if (rem[c] > 0) rem[c]--;
        end
        for (int w = 0; w < NW; w++) msk[w] = 0;
        if (e_v) begin msk[e_w] = 1; ptr[0] = e_w / 2; end
        if (o_v) begin msk[o_w] = 1; ptr[1] = o_w / 2; end
        #1;
    endtask

    task automatic idle(input int n);
        rdy = '0;
        repeat (n) step();
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        errors++;
        $display("FAIL R11 watchdog expired: actual %0d expected %0d", 0, 1);
        finish_run();
    end

    initial begin
        rst_n = 1'b0;
        rdy   = '0;
        clsv  = '0;
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(col_busy == 4'b0, "R1", "busy during reset", int'(col_busy), 0);
        chk(!ev_gnt_vld && !od_gnt_vld, "R1", "grant during reset",
            int'(ev_gnt_vld | od_gnt_vld), 0);
        @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 / R12: first priority after reset, two integer warps split the cores
        for (int w = 0; w < NW; w++) set_cls(w, 0);
        rdy = '1;
        step();
        chk(obs_ev_vld && obs_ev_warp == 0, "R1", "even first warp", obs_ev_warp, 0);
        chk(obs_od_vld && obs_od_warp == 1, "R1", "odd first warp", obs_od_warp, 1);
        chk(obs_ev_cols == 4'b0001, "R12", "even core column", int'(obs_ev_cols), 1);
        chk(obs_od_cols == 4'b0010, "R12", "odd core column", int'(obs_od_cols), 2);
        repeat (20) step();

        // R10: valid classes but nothing ready
        idle(10);
        repeat (3) begin
            step();
            chk(!obs_ev_vld && !obs_od_vld, "R10", "grant without ready",
                int'(obs_ev_vld | obs_od_vld), 0);
        end

        // R2: invalid classes 5..7 never issue
        for (int w = 0; w < NW; w++) set_cls(w, 5 + (w % 3));
        rdy = '1;
        repeat (4) begin
            step();
            chk(!obs_ev_vld && !obs_od_vld, "R2", "invalid class granted",
                int'(obs_ev_vld | obs_od_vld), 0);
        end

        // R5 / R8: FP64 on even side blocks an odd integer warp
        idle(10);
        set_cls(0, 2); set_cls(1, 0);
        rdy[0] = 1'b1; rdy[1] = 1'b1;
        step();
        chk(obs_ev_vld && obs_ev_warp == 0, "R5", "FP64 grant", obs_ev_warp, 0);
        chk(obs_ev_cols == 4'b0011, "R5", "FP64 columns", int'(obs_ev_cols), 3);
        chk(!obs_od_vld, "R8", "odd loses core", int'(obs_od_vld), 0);
        rdy[0] = 1'b0;
        step();
        chk(obs_busy[1:0] == 2'b11, "R5", "cores held by FP64", int'(obs_busy[1:0]), 3);
        chk(!obs_od_vld, "R5", "core grant during FP64", int'(obs_od_vld), 0);
        step();
        chk(obs_od_vld && obs_od_warp == 1, "R8", "odd retries same warp", obs_od_warp, 1);
        chk(obs_od_cols == 4'b0001, "R2", "odd integer column", int'(obs_od_cols), 1);
        rdy[1] = 1'b0;

        // R8: both want load/store; even wins, odd retries
        idle(10);
        set_cls(2, 3); set_cls(3, 3);
        rdy[2] = 1'b1; rdy[3] = 1'b1;
        step();
        chk(obs_ev_vld && obs_ev_cols == 4'b0100, "R8", "even wins load/store",
            int'(obs_ev_cols), 4);
        chk(!obs_od_vld, "R8", "odd loses load/store", int'(obs_od_vld), 0);
        rdy[2] = 1'b0;
        step();
        chk(obs_busy[2] == 1'b1, "R3", "load/store busy", int'(obs_busy[2]), 1);
        chk(!obs_od_vld, "R4", "grant to busy column", int'(obs_od_vld), 0);
        step();
        chk(obs_od_vld && obs_od_warp == 3, "R8", "odd retry grant", obs_od_warp, 3);
        rdy[3] = 1'b0;

        // R9: a still-ready warp skips one cycle after its grant
        idle(10);
        set_cls(0, 0);
        rdy[0] = 1'b1;
        step();
        chk(obs_ev_vld && obs_ev_cols == 4'b0001, "R9", "first integer grant",
            int'(obs_ev_cols), 1);
        step();
        chk(!obs_ev_vld, "R9", "regrant next cycle", int'(obs_ev_vld), 0);
        step();
        chk(obs_ev_vld && obs_ev_warp == 0 && obs_ev_cols == 4'b0001, "R9",
            "regrant after gap", int'(obs_ev_cols), 1);
        rdy[0] = 1'b0;

        // R12: integer and special-function together
        idle(10);
        set_cls(4, 0); set_cls(5, 4);
        rdy[4] = 1'b1; rdy[5] = 1'b1;
        step();
        chk(obs_ev_vld && obs_od_vld, "R12", "dual grant", int'(obs_ev_vld & obs_od_vld), 1);
        chk(obs_od_cols == 4'b1000, "R2", "special-function column", int'(obs_od_cols), 8);
        rdy[4] = 1'b0; rdy[5] = 1'b0;

        // R11: eight special-function warps
        idle(12);
        for (int i = 0; i < 8; i++) begin
            set_cls(2*i, 4);
            rdy[2*i] = 1'b1;
        end
        begin
            int n, ngr, first, last, endc, gap_bad;
            n = 0; ngr = 0; first = -1; last = -1; endc = -1; gap_bad = 0;
            while (endc < 0 && n < 200) begin
                step();
                if (obs_ev_vld && obs_ev_cols == 4'b1000) begin
                    if (ngr > 0 && (n - last) != 8) gap_bad++;
                    if (first < 0) first = n;
                    last = n;
                    ngr++;
                    rdy[obs_ev_warp] = 1'b0;
                end else if (ngr == 8 && !obs_busy[3]) begin
                    endc = n;
                end
                n++;
            end
            chk(ngr == 8, "R11", "special-function grant count", ngr, 8);
            chk(first == 0, "R11", "first special-function grant cycle", first, 0);
            chk(gap_bad == 0, "R11", "grant spacing errors", gap_bad, 0);
            chk(endc - first == 64, "R11", "cycles to drain", endc - first, 64);
        end

        // Mixed random traffic against the model (R4, R6, R7, R10)
        idle(10);
        repeat (3000) begin
            for (int w = 0; w < NW; w++) begin
                rdy[w] = (($urandom % 3) != 0);
                if (($urandom % 6) == 0) set_cls(w, 5 + int'($urandom % 3));
                else                     set_cls(w, int'($urandom % 5));
            end
            step();
        end

        finish_run();
    end

endmodule